// File: doc/BRIEF.md
# Deterministic Hardware Loop Sequencer

This block is the fetch-address and loop-control unit of a statically scheduled processor that has no branch instructions. Once started, it hands program memory one instruction address per enabled clock cycle. The only way the address can leave its sequential path is a loop reload. Each loop is defined by a descriptor holding a body start address, a body end address and an iteration count, and these values are fixed before the program runs. Because reloads are decided only by these descriptors, a program's run time is a number of cycles known at design time.

Several programs can sit in program memory at once. For each program, the block receives a first address, a last address and a table of loop descriptors. A start strobe picks one program through the select input and runs it. When the last address has been fetched, the block drops its running flag and raises a one-cycle finished pulse, so that an outside controller can launch the next program. The enable input stops every piece of state in place. This lets surrounding logic be swapped out without the sequencer drifting. A low reset returns the block to idle.

Top module: `hwloop_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the fetch address is 0 and both the running flag and the finished pulse are 0.
- R2: When enable and start are high at a clock edge while the block is idle, the following cycle shows the first address of the selected program on the fetch address, with the running flag at 1.
- R3: In an enabled running cycle with no loop reload, the fetch address steps up by exactly 1, unless it equals the program's last address.
- R4: When the fetch address matches a descriptor's end address and that descriptor still has passes left, the next fetch address is the descriptor's start address. A descriptor with count N runs its body exactly N times and then falls through to end+1.
- R5: An iteration count of 0 behaves exactly like a count of 1: the body runs once and is never reloaded.
- R6: Lower descriptor index means inner loop. If several descriptors share the current end address, the lowest-index one with passes left wins the reload. Lower-index descriptors that have run out of passes are rearmed, so the next entry into them repeats their full count.
- R7: Fetching the last address with no reload clears the running flag at the next edge. At that same edge the finished pulse goes high for exactly one cycle, and the fetch address holds the last address.
- R8: While enable is low, the fetch address, the running flag and the loop pass counters do not change, and a start strobe has no effect.
- R9: A start strobe that arrives while a program is running is ignored. The running program finishes with the same cycle count it would have had otherwise.
- R10: The program select input is sampled only by an accepted start. Changing it during a run does not alter the addresses fetched.
- R11: With enable held high, the number of cycles with the running flag high equals the length of the straight-line program plus every loop body repeated (count−1) times, including nested repetition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance enable; low freezes all state |
| start_i | input | 1 | Start strobe, accepted only when idle and enabled |
| prog_sel_i | input | PSW | Index of the program to start |
| prog_first_i | input | NPROG*AW | First address of each program, program p at bits p*AW |
| prog_last_i | input | NPROG*AW | Last address of each program |
| loop_start_i | input | NPROG*NLOOP*AW | Loop body start, descriptor (p*NLOOP+i) at bits (p*NLOOP+i)*AW |
| loop_end_i | input | NPROG*NLOOP*AW | Loop body end address, same packing |
| loop_count_i | input | NPROG*NLOOP*CW | Iteration count, descriptor (p*NLOOP+i) at bits (p*NLOOP+i)*CW |
| fetch_addr_o | output | AW | Address presented to program memory |
| running_o | output | 1 | High while a program is executing |
| done_o | output | 1 | One-cycle pulse after the last address was fetched |

## Verification
Directed programs cover four cases, each checked against a hand-derived total cycle count: straight-line code, a single loop with count 3, the same loop with counts 0 and 1, and two loops sharing one end address. Matching run lengths separates correct reload and rearm behaviour from off-by-one pass counting and from a wrong priority choice. Randomly nested four-deep loop sets are then run in lockstep against a bench model while enable drops at random, stray starts arrive and the select input changes. This shows whether freezing and input-ignoring hold in any state, not just in the directed ones.

// File: rtl/hlseq_pkg.sv
package hlseq_pkg;

   // Source of the next fetch address, chosen once per cycle.
   typedef enum logic [1:0] {
      NXT_HOLD = 2'd0,
      NXT_INC  = 2'd1,
      NXT_LOOP = 2'd2,
      NXT_DONE = 2'd3
   } nxt_e;

endpackage

// File: rtl/hlseq_slot.sv
module hlseq_slot #(
   parameter int AW = 8,
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active_i,
   input  logic          clear_i,
   input  logic          win_i,
   input  logic          refill_i,
   input  logic [AW-1:0] pc_i,
   input  logic [AW-1:0] end_i,
   input  logic [CW-1:0] count_i,
   output logic          hit_o,
   output logic          want_o
);

   logic [CW-1:0] pass_q;
   logic [CW-1:0] eff_cnt;

   // count 0 is treated as a single pass (R5)
   assign eff_cnt = (count_i == '0) ? CW'(1) : count_i;
   assign hit_o   = active_i && (pc_i == end_i);
   assign want_o  = hit_o && (({1'b0, pass_q} + 1'b1) < {1'b0, eff_cnt});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pass_q <= '0;
      else if (clear_i)  pass_q <= '0;
      else if (win_i)    pass_q <= pass_q + 1'b1;
      else if (refill_i) pass_q <= '0;
   end

   // pass counter never reaches the effective count while running (R4)
   p_pass_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      active_i |-> (pass_q < eff_cnt));

   // a rearmed descriptor starts from zero passes (R6)
   p_refill_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (refill_i && !win_i && !clear_i) |=> (pass_q == '0));

endmodule

// File: rtl/hlseq_prio.sv
module hlseq_prio #(
   parameter int N = 4
) (
   input  logic [N-1:0] want_i,
   output logic [N-1:0] win_o,
   output logic [N-1:0] blk_o,
   output logic         any_o
);

   // blk_o[i] is set when a lower-index (inner) descriptor requests a reload
   assign blk_o[0] = 1'b0;
   for (genvar g = 1; g < N; g++) begin : g_chain
      assign blk_o[g] = blk_o[g-1] | want_i[g-1];
   end

   assign win_o = want_i & ~blk_o;
   assign any_o = |want_i;

endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq
   import hlseq_pkg::*;
#(
   parameter  int AW    = 8,
   parameter  int CW    = 6,
   parameter  int NLOOP = 4,
   parameter  int NPROG = 2,
   localparam int PSW   = (NPROG > 1) ? $clog2(NPROG) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en_i,
   input  logic                      start_i,
   input  logic [PSW-1:0]            prog_sel_i,
   input  logic [NPROG*AW-1:0]       prog_first_i,
   input  logic [NPROG*AW-1:0]       prog_last_i,
   input  logic [NPROG*NLOOP*AW-1:0] loop_start_i,
   input  logic [NPROG*NLOOP*AW-1:0] loop_end_i,
   input  logic [NPROG*NLOOP*CW-1:0] loop_count_i,
   output logic [AW-1:0]             fetch_addr_o,
   output logic                      running_o,
   output logic                      done_o
);

   if (AW < 2) begin : g_bad_aw
      $error("hwloop_seq: AW must be at least 2");
   end
   if (CW < 1) begin : g_bad_cw
      $error("hwloop_seq: CW must be at least 1");
   end
   if (NLOOP < 1 || NLOOP > 8) begin : g_bad_nloop
      $error("hwloop_seq: NLOOP must lie in 1..8");
   end
   if (NPROG < 2 || (1 << PSW) != NPROG) begin : g_bad_nprog
      $error("hwloop_seq: NPROG must be a power of two, at least 2");
   end

   logic [PSW-1:0] sel_q;
   logic [AW-1:0]  pc_q;
   logic           run_q;
   logic           done_q;

   logic [AW-1:0]  lp_start [NLOOP];
   logic [AW-1:0]  lp_end   [NLOOP];
   logic [CW-1:0]  lp_cnt   [NLOOP];
   logic [NLOOP-1:0] hit, want, win, blk, refill;
   logic           any_reload;
   logic           step, accept;
   logic [AW-1:0]  first_new, last_cur, target;
   logic           at_last;
   nxt_e           nxt;

   assign step      = en_i && run_q;
   assign accept    = en_i && !run_q && start_i;
   assign first_new = prog_first_i[int'(prog_sel_i)*AW +: AW];
   assign last_cur  = prog_last_i[int'(sel_q)*AW +: AW];
   assign at_last   = (pc_q == last_cur);

   for (genvar g = 0; g < NLOOP; g++) begin : g_slot
      assign lp_start[g] = loop_start_i[(int'(sel_q)*NLOOP + g)*AW +: AW];
      assign lp_end[g]   = loop_end_i[(int'(sel_q)*NLOOP + g)*AW +: AW];
      assign lp_cnt[g]   = loop_count_i[(int'(sel_q)*NLOOP + g)*CW +: CW];
      assign refill[g]   = hit[g] && !blk[g] && !want[g];

      hlseq_slot #(.AW(AW), .CW(CW)) i_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .active_i (step),
         .clear_i  (accept),
         .win_i    (win[g]),
         .refill_i (refill[g]),
         .pc_i     (pc_q),
         .end_i    (lp_end[g]),
         .count_i  (lp_cnt[g]),
         .hit_o    (hit[g]),
         .want_o   (want[g])
      );
   end

   hlseq_prio #(.N(NLOOP)) i_prio (
      .want_i (want),
      .win_o  (win),
      .blk_o  (blk),
      .any_o  (any_reload)
   );

   always_comb begin
      target = '0;
      for (int i = 0; i < NLOOP; i++) begin
         if (win[i]) target = target | lp_start[i];
      end
   end

   always_comb begin
      nxt = NXT_HOLD;
      if (step) begin
         if (any_reload)   nxt = NXT_LOOP;
         else if (at_last) nxt = NXT_DONE;
         else              nxt = NXT_INC;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         pc_q   <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            sel_q <= prog_sel_i;
            pc_q  <= first_new;
            run_q <= 1'b1;
         end
         case (nxt)
            NXT_INC:  pc_q <= pc_q + 1'b1;
            NXT_LOOP: pc_q <= target;
            NXT_DONE: begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
            default:  ;
         endcase
      end
   end

   assign fetch_addr_o = pc_q;
   assign running_o    = run_q;
   assign done_o       = done_q;

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (run_q && pc_q == $past(first_new)));

   p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !any_reload && !at_last) |=> (pc_q == $past(pc_q) + 1'b1));

   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && any_reload) |=> (pc_q == $past(target)));

   p_win_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(win) <= 1);

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!run_q && $stable(pc_q)));

   p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> ($stable(pc_q) && $stable(run_q)));

   p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && $past(run_q) |-> $stable(sel_q));

endmodule

// File: tb/test_hwloop_seq.sv
module test_hwloop_seq;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int CW = 6;
   localparam int NL = 4;
   localparam int NP = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic start = 1'b0;
   logic [0:0] sel = 1'b0;

   logic [AW-1:0] pf [NP];
   logic [AW-1:0] pl [NP];
   logic [AW-1:0] ls [NP][NL];
   logic [AW-1:0] le [NP][NL];
   logic [CW-1:0] lc [NP][NL];

   logic [NP*AW-1:0]    prog_first, prog_last;
   logic [NP*NL*AW-1:0] loop_start, loop_end;
   logic [NP*NL*CW-1:0] loop_count;

   logic [AW-1:0] fetch;
   logic          running, done;

   int n_cmp = 0;
   int n_bad = 0;
   bit chk_on = 1'b0;
   string tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int p = 0; p < NP; p++) begin
         prog_first[p*AW +: AW] = pf[p];
         prog_last[p*AW +: AW]  = pl[p];
         for (int i = 0; i < NL; i++) begin
            loop_start[(p*NL+i)*AW +: AW] = ls[p][i];
            loop_end[(p*NL+i)*AW +: AW]   = le[p][i];
            loop_count[(p*NL+i)*CW +: CW] = lc[p][i];
         end
      end
   end

   hwloop_seq #(.AW(AW), .CW(CW), .NLOOP(NL), .NPROG(NP)) i_hwloop_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (en),
      .start_i      (start),
      .prog_sel_i   (sel),
      .prog_first_i (prog_first),
      .prog_last_i  (prog_last),
      .loop_start_i (loop_start),
      .loop_end_i   (loop_end),
      .loop_count_i (loop_count),
      .fetch_addr_o (fetch),
      .running_o    (running),
      .done_o       (done)
   );

   // ---------------- reference model built from the requirements ----------
   logic [AW-1:0] m_pc = '0;
   bit  m_run = 1'b0;
   bit  m_done = 1'b0;
   int  m_sel = 0;
   int  m_pass [NL];

   function automatic int eff(input int c);
      return (c == 0) ? 1 : c;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pc = '0; m_run = 1'b0; m_done = 1'b0; m_sel = 0;
         for (int i = 0; i < NL; i++) m_pass[i] = 0;
      end else if (en) begin
         m_done = 1'b0;
         if (m_run) begin
            int w;
            w = -1;
            for (int i = 0; i < NL; i++) begin
               if (le[m_sel][i] == m_pc && w < 0) begin
                  if (m_pass[i] + 1 < eff(int'(lc[m_sel][i]))) begin
                     w = i;                       // R6 inner first
                     m_pass[i] = m_pass[i] + 1;
                  end else begin
                     m_pass[i] = 0;               // R6 rearm
                  end
               end
            end
            if (w >= 0) m_pc = ls[m_sel][w];      // R4
            else if (m_pc == pl[m_sel]) begin     // R7
               m_run = 1'b0; m_done = 1'b1;
            end else m_pc = m_pc + 1'b1;          // R3
         end else if (start) begin                // R2
            m_sel = int'(sel);
            m_pc = pf[m_sel];
            m_run = 1'b1;
            for (int i = 0; i < NL; i++) m_pass[i] = 0;
         end
      end else begin
         m_done = 1'b0;                           // R8 freeze
      end
   end

   // lockstep comparison, sampled away from the active edge
   always @(negedge clk) begin
      if (chk_on) begin
         n_cmp++;
         if (fetch !== m_pc || running !== m_run || done !== m_done) begin
            n_bad++;
            $display("FAIL %s: pc/run/done = %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, fetch, running, done, m_pc, m_run, m_done);
         end
      end
   end

   task automatic check_eq(input string t, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", t, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic clear_prog(input int p, input int f, input int l);
      pf[p] = AW'(f);
      pl[p] = AW'(l);
      for (int i = 0; i < NL; i++) begin
         ls[p][i] = 8'hFF; le[p][i] = 8'hFF; lc[p][i] = 1;
      end
   endtask

   task automatic set_loop(input int p, input int i, input int s, input int e, input int c);
      ls[p][i] = AW'(s); le[p][i] = AW'(e); lc[p][i] = CW'(c);
   endtask

   // Start program s, then follow it to completion. poke>0 injects a start
   // strobe and a select change on that cycle; chaos randomises enable,
   // start and select every cycle.
   task automatic run_prog(input int s, input int exp_cyc, input string t,
                           input bit chk_cyc, input int poke, input bit chaos);
      int cyc;
      int guard;
      tag = t;
      sel = 1'(s); en = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0; guard = 0;
      forever begin
         if (running) cyc++;
         if (done) break;
         guard++;
         if (guard > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL %s: no finished pulse, actual none expected one", t);
            break;
         end
         start = 1'b0;
         if (poke > 0 && cyc == poke) begin
            start = 1'b1; sel = 1'(1 - s);
         end
         if (chaos) begin
            en    = ($urandom % 10) != 0;
            start = ($urandom % 20) == 0;
            sel   = 1'($urandom % 2);
         end
         @(negedge clk);
      end
      start = 1'b0; en = 1'b1;
      if (chk_cyc) check_eq({t, " cycle count"}, cyc, exp_cyc);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      void'($urandom(32'd20240611));
      clear_prog(0, 10, 20);
      clear_prog(1, 5, 15);

      // R1: reset state
      @(negedge clk);
      chk_on = 1'b1;
      check_eq("R1 running in reset", int'(running), 0);
      check_eq("R1 fetch in reset", int'(fetch), 0);
      rst_n = 1'b1; en = 1'b1;
      @(negedge clk);
      check_eq("R1 done after reset", int'(done), 0);

      // R2 R3 R7 R11: straight-line program, 11 addresses
      run_prog(0, 11, "R2 R3 R7 R11 straight", 1'b1, 0, 1'b0);
      check_eq("R7 pc holds last", int'(fetch), 20);

      // R4 R11: one loop 7..9 three times: 11 + 2*3
      set_loop(1, 0, 7, 9, 3);
      run_prog(1, 17, "R4 R11 single loop", 1'b1, 0, 1'b0);

      // R5: count 0 behaves as 1
      set_loop(1, 0, 7, 9, 0);
      run_prog(1, 11, "R5 count zero", 1'b1, 0, 1'b0);
      set_loop(1, 0, 7, 9, 1);
      run_prog(1, 11, "R5 count one", 1'b1, 0, 1'b0);

      // R6: inner 4..6 x2 and outer 2..6 x3 share end 6: 2 + 3*8 + 14
      clear_prog(0, 0, 20);
      set_loop(0, 0, 4, 6, 2);
      set_loop(0, 1, 2, 6, 3);
      run_prog(0, 40, "R6 shared end nesting", 1'b1, 0, 1'b0);

      // R9 R10: stray start and select change mid-run are ignored
      set_loop(1, 0, 7, 9, 3);
      run_prog(1, 17, "R9 R10 start ignored", 1'b1, 4, 1'b0);

      // R8: freeze while enable is low, start attempted meanwhile
      begin
         logic [AW-1:0] held;
         tag = "R8 freeze";
         sel = 1'b1; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (3) @(negedge clk);
         held = fetch;
         en = 1'b0; start = 1'b1; sel = 1'b0;
         repeat (6) @(negedge clk);
         check_eq("R8 pc frozen", int'(fetch), int'(held));
         check_eq("R8 running frozen", int'(running), 1);
         start = 1'b0; en = 1'b1;
         while (!done) @(negedge clk);
         check_eq("R8 resumed pc reaches last", int'(fetch), 15);
         @(negedge clk);
      end

      // Random nested programs with random enable, strays and selects
      for (int k = 0; k < 30; k++) begin
         for (int p = 0; p < NP; p++) begin
            int f, l, lo, hi;
            f = $urandom_range(0, 100);
            l = f + $urandom_range(4, 30);
            clear_prog(p, f, l);
            lo = f; hi = l;
            for (int i = NL - 1; i >= 0; i--) begin
               int s, e;
               s = $urandom_range(lo, hi);
               e = $urandom_range(s, hi);
               set_loop(p, i, s, e, $urandom_range(0, 3));
               lo = s; hi = e;
            end
         end
         run_prog(k % 2, 0, "R3 R4 R5 R6 R8 R9 R10 random", 1'b0, 0, 1'b1);
      end

      chk_on = 1'b0;
      finish_up();
   end

endmodule